// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves translation-buffer misses in hardware. The translation buffer hands it a missing 44-bit virtual address. The walker then reads up to three page table entries from memory, one level after another, starting from a root table base held in a register. The result is either a physical address that can be loaded into the buffer, or a page fault.

The virtual address is split into three index fields of unequal width: 11, 11 and 10 bits. These sit above a 12-bit page offset. If a valid entry at the middle level is marked as a leaf, the walk stops there. It then returns a 4 MB mapping, and the low 22 address bits pass through as the offset.

Memory is reached through a read port with a valid/ready request side and a valid-only response side. Only one read is ever in flight. The walker handles one miss at a time. It refuses new misses until it has returned the result of the current one.

Entry format used throughout: bit 0 is the valid flag and bit 1 is the leaf flag. Bits PA_W-1:12 hold the frame number of the next table or of the data page. All other bits are ignored.

Top module: `ptw3_walker`

## Requirements
- R1: While reset is held, and after it is released with no miss offered, miss_ready_o is 1 and both mem_req_valid_o and fill_valid_o are 0.
- R2: The first read of a walk goes to the root base plus 8 times virtual address bits 43:33.
- R3: The second read goes to (level-1 entry bits PA_W-1:12 followed by 12 zero bits) plus 8 times VA bits 32:22. The third read goes to the same construction from the level-2 entry, plus 8 times VA bits 21:12.
- R4: When all three entries are valid and the level-2 entry has leaf=0, exactly three reads are made. The fill then reports fault=0, large=0, level=3 and pa = {level-3 entry bits PA_W-1:12, VA bits 11:0}.
- R5: A valid level-2 entry with leaf=1 ends the walk after two reads. The fill reports large=1, fault=0, level=2 and pa = {entry bits PA_W-1:22, VA bits 21:0}.
- R6: An entry with valid=0 at level N ends the walk after N reads. The fill reports fault=1, large=0 and level=N.
- R7: Only one memory read is outstanding. A request holds its address steady until it is accepted. No new request is raised until the response for the previous one has arrived.
- R8: miss_ready_o is 1 only while idle. Misses offered during a walk are ignored and do not change its result.
- R9: fill_valid_o is a one-cycle pulse. In the next cycle miss_ready_o is 1 again.
- R10: A valid level-1 entry with leaf=1 is a fault at level 1. The leaf flag of a level-3 entry has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_root_i | input | PA_W | Root page table base |
| miss_valid_i | input | 1 | Miss request offered |
| miss_va_i | input | VA_W | Missing virtual address |
| miss_ready_o | output | 1 | Walker idle, miss accepted |
| fill_valid_o | output | 1 | Walk result pulse |
| fill_fault_o | output | 1 | Walk ended in a page fault |
| fill_large_o | output | 1 | Result is a 4 MB mapping |
| fill_level_o | output | 2 | Level where the walk ended (1..3) |
| fill_pa_o | output | PA_W | Translated physical address |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | PA_W | Entry address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | PTE_W | Entry read from memory |

## Verification
The bench uses the default parameters: 40-bit physical addresses, 64-bit entries and an 11/11/10/12 split. These settings put every index field boundary and both leaf sizes within reach. The random entries carry junk in the high and unused bits, which tests that only the defined fields matter. The memory model adds random request stalls and response latencies of zero to two cycles, so every walk runs against a different handshake timing. Junk misses are offered while reads are pending.

// File: rtl/ptw3_pkg.sv
package ptw3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD1   = 3'd1,
    ST_RD2   = 3'd2,
    ST_RD3   = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } walk_state_e;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_LEAF_BIT  = 1;
  localparam int ENT_SIZE_LG2  = 3;
endpackage

// File: rtl/ptw3_rst_sync.sv
module ptw3_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ptw3_index_sel.sv
module ptw3_index_sel
  import ptw3_pkg::*;
#(
  parameter int L1_W  = 11,
  parameter int L2_W  = 11,
  parameter int L3_W  = 10,
  parameter int OFF_W = 12,
  parameter int VA_W  = L1_W + L2_W + L3_W + OFF_W,
  parameter int IDX_W = 11
) (
  input  walk_state_e      state_i,
  input  logic [VA_W-1:0]  va_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int L2_LO = OFF_W + L3_W;
  localparam int L1_LO = L2_LO + L2_W;

  always_comb begin
    unique case (state_i)
      ST_RD1:  idx_o = IDX_W'(va_i[L1_LO +: L1_W]);
      ST_RD2:  idx_o = IDX_W'(va_i[L2_LO +: L2_W]);
      ST_RD3:  idx_o = IDX_W'(va_i[OFF_W +: L3_W]);
      default: idx_o = '0;
    endcase
  end
endmodule

// File: rtl/ptw3_entry_addr.sv
module ptw3_entry_addr
  import ptw3_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int IDX_W = 11
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);
  assign addr_o = base_i + (PA_W'(idx_i) << ENT_SIZE_LG2);
endmodule

// File: rtl/ptw3_pte_eval.sv
module ptw3_pte_eval
  import ptw3_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int PTE_W  = 64,
  parameter int VA_W   = 44,
  parameter int OFF_W  = 12,
  parameter int LG_OFF = 22
) (
  input  walk_state_e      state_i,
  input  logic [PTE_W-1:0] pte_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             fault_o,
  output logic             done_o,
  output logic             large_o,
  output logic [PA_W-1:0]  next_base_o,
  output logic [PA_W-1:0]  pa_o
);
  logic            pte_v;
  logic            pte_leaf;
  logic [PA_W-1:0] pa_small;
  logic [PA_W-1:0] pa_large;

  assign pte_v       = pte_i[PTE_VALID_BIT];
  assign pte_leaf    = pte_i[PTE_LEAF_BIT];
  assign next_base_o = {pte_i[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign pa_small    = {pte_i[PA_W-1:OFF_W], va_i[OFF_W-1:0]};
  assign pa_large    = {pte_i[PA_W-1:LG_OFF], va_i[LG_OFF-1:0]};

  always_comb begin
    fault_o = 1'b0;
    done_o  = 1'b0;
    large_o = 1'b0;
    pa_o    = pa_small;
    unique case (state_i)
      ST_RD1: begin
        fault_o = !pte_v || pte_leaf;
      end
      ST_RD2: begin
        fault_o = !pte_v;
        if (pte_v && pte_leaf) begin
          done_o  = 1'b1;
          large_o = 1'b1;
          pa_o    = pa_large;
        end
      end
      ST_RD3: begin
        fault_o = !pte_v;
        done_o  = pte_v;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptw3_ctrl.sv
module ptw3_ctrl
  import ptw3_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int VA_W = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_i,
  input  logic            miss_valid_i,
  input  logic [VA_W-1:0] miss_va_i,
  input  logic            req_ready_i,
  input  logic            rsp_valid_i,
  input  logic            ev_fault_i,
  input  logic            ev_done_i,
  input  logic            ev_large_i,
  input  logic [PA_W-1:0] ev_next_base_i,
  input  logic [PA_W-1:0] ev_pa_i,
  output walk_state_e     state_o,
  output logic [VA_W-1:0] va_o,
  output logic [PA_W-1:0] base_o,
  output logic            req_valid_o,
  output logic            miss_ready_o,
  output logic            fill_valid_o,
  output logic            fill_fault_o,
  output logic            fill_large_o,
  output logic [1:0]      fill_level_o,
  output logic [PA_W-1:0] fill_pa_o
);
  walk_state_e     state_q, state_d;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] base_q, base_d;
  logic            sent_q, sent_d;
  logic [PA_W-1:0] pa_q;
  logic            large_q, fault_q;
  logic [1:0]      level_q, cur_level;
  logic            in_read, accept, req_fire, rsp_take;
  logic            va_en, base_en, res_en;

  assign in_read  = (state_q == ST_RD1) || (state_q == ST_RD2) || (state_q == ST_RD3);
  assign accept   = (state_q == ST_IDLE) && miss_valid_i;
  assign req_fire = in_read && !sent_q && req_ready_i;
  assign rsp_take = in_read && sent_q && rsp_valid_i;

  always_comb begin
    unique case (state_q)
      ST_RD1:  cur_level = 2'd1;
      ST_RD2:  cur_level = 2'd2;
      ST_RD3:  cur_level = 2'd3;
      default: cur_level = 2'd0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    sent_d  = sent_q;
    base_d  = base_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RD1;
          sent_d  = 1'b0;
          base_d  = root_i;
        end
      end
      ST_RD1, ST_RD2, ST_RD3: begin
        if (req_fire) sent_d = 1'b1;
        if (rsp_take) begin
          sent_d = 1'b0;
          if (ev_fault_i)     state_d = ST_FAULT;
          else if (ev_done_i) state_d = ST_DONE;
          else begin
            base_d  = ev_next_base_i;
            state_d = (state_q == ST_RD1) ? ST_RD2 : ST_RD3;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign va_en   = accept;
  assign base_en = accept || rsp_take;
  assign res_en  = rsp_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     va_q <= '0;
    else if (va_en) va_q <= miss_va_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      large_q <= 1'b0;
      fault_q <= 1'b0;
      level_q <= 2'd0;
    end else if (res_en) begin
      pa_q    <= ev_pa_i;
      large_q <= ev_large_i && !ev_fault_i;
      fault_q <= ev_fault_i;
      level_q <= cur_level;
    end
  end

  assign state_o      = state_q;
  assign va_o         = va_q;
  assign base_o       = base_q;
  assign req_valid_o  = in_read && !sent_q;
  assign miss_ready_o = (state_q == ST_IDLE);
  assign fill_valid_o = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fill_fault_o = fault_q;
  assign fill_large_o = large_q;
  assign fill_level_o = level_q;
  assign fill_pa_o    = pa_q;
endmodule

// File: rtl/ptw3_walker.sv
module ptw3_walker
  import ptw3_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int PTE_W = 64,
  parameter int L1_W  = 11,
  parameter int L2_W  = 11,
  parameter int L3_W  = 10,
  parameter int OFF_W = 12,
  parameter int VA_W  = L1_W + L2_W + L3_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pt_root_i,
  input  logic             miss_valid_i,
  input  logic [VA_W-1:0]  miss_va_i,
  output logic             miss_ready_o,
  output logic             fill_valid_o,
  output logic             fill_fault_o,
  output logic             fill_large_o,
  output logic [1:0]       fill_level_o,
  output logic [PA_W-1:0]  fill_pa_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i
);
  localparam int LG_OFF = OFF_W + L3_W;
  localparam int IDX_W  = (L1_W > L2_W) ? ((L1_W > L3_W) ? L1_W : L3_W)
                                        : ((L2_W > L3_W) ? L2_W : L3_W);

  logic            rst_int_n;
  walk_state_e     state;
  logic [VA_W-1:0] va_cur;
  logic [PA_W-1:0] base_cur;
  logic [IDX_W-1:0] idx;
  logic            ev_fault, ev_done, ev_large;
  logic [PA_W-1:0] ev_next_base, ev_pa;

  ptw3_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ptw3_index_sel #(
    .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .OFF_W(OFF_W), .VA_W(VA_W), .IDX_W(IDX_W)
  ) idx_i (
    .state_i (state),
    .va_i    (va_cur),
    .idx_o   (idx)
  );

  ptw3_entry_addr #(.PA_W(PA_W), .IDX_W(IDX_W)) addr_i (
    .base_i (base_cur),
    .idx_i  (idx),
    .addr_o (mem_req_addr_o)
  );

  ptw3_pte_eval #(
    .PA_W(PA_W), .PTE_W(PTE_W), .VA_W(VA_W), .OFF_W(OFF_W), .LG_OFF(LG_OFF)
  ) eval_i (
    .state_i     (state),
    .pte_i       (mem_rsp_data_i),
    .va_i        (va_cur),
    .fault_o     (ev_fault),
    .done_o      (ev_done),
    .large_o     (ev_large),
    .next_base_o (ev_next_base),
    .pa_o        (ev_pa)
  );

  ptw3_ctrl #(.PA_W(PA_W), .VA_W(VA_W)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .root_i         (pt_root_i),
    .miss_valid_i   (miss_valid_i),
    .miss_va_i      (miss_va_i),
    .req_ready_i    (mem_req_ready_i),
    .rsp_valid_i    (mem_rsp_valid_i),
    .ev_fault_i     (ev_fault),
    .ev_done_i      (ev_done),
    .ev_large_i     (ev_large),
    .ev_next_base_i (ev_next_base),
    .ev_pa_i        (ev_pa),
    .state_o        (state),
    .va_o           (va_cur),
    .base_o         (base_cur),
    .req_valid_o    (mem_req_valid_o),
    .miss_ready_o   (miss_ready_o),
    .fill_valid_o   (fill_valid_o),
    .fill_fault_o   (fill_fault_o),
    .fill_large_o   (fill_large_o),
    .fill_level_o   (fill_level_o),
    .fill_pa_o      (fill_pa_o)
  );
endmodule

// File: rtl/ptw3_walker_chk.sv
module ptw3_walker_chk #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miss_valid_i,
  input logic            miss_ready_o,
  input logic            fill_valid_o,
  input logic            fill_fault_o,
  input logic            fill_large_o,
  input logic [1:0]      fill_level_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R7
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> !miss_ready_o);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_i && miss_ready_o |=> !miss_ready_o);

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |=> !fill_valid_o && miss_ready_o);

  // R5
  large_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o && fill_large_o |-> !fill_fault_o && fill_level_o == 2'd2);

  // R6
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> fill_level_o != 2'd0);
endmodule

bind ptw3_walker ptw3_walker_chk #(.PA_W(PA_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_valid_i    (miss_valid_i),
  .miss_ready_o    (miss_ready_o),
  .fill_valid_o    (fill_valid_o),
  .fill_fault_o    (fill_fault_o),
  .fill_large_o    (fill_large_o),
  .fill_level_o    (fill_level_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o)
);

// File: tb/ptw3_walker_tb_top.sv
`timescale 1ns/1ps
module ptw3_walker_tb_top;
  localparam int PA_W = 40;
  localparam int PTE_W = 64;
  localparam int VA_W = 44;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [PA_W-1:0]  pt_root;
  logic             miss_valid;
  logic [VA_W-1:0]  miss_va;
  logic             miss_ready;
  logic             fill_valid, fill_fault, fill_large;
  logic [1:0]       fill_level;
  logic [PA_W-1:0]  fill_pa;
  logic             mem_req_valid;
  logic             mem_req_ready;
  logic [PA_W-1:0]  mem_req_addr;
  logic             mem_rsp_valid;
  logic [PTE_W-1:0] mem_rsp_data;

  int checks = 0;
  int failures = 0;

  logic [PTE_W-1:0] mem [longint unsigned];
  int               reads;
  logic [PA_W-1:0]  rd_addr [4];
  bit               pend;
  int               lat;
  logic [PA_W-1:0]  pend_addr;
  bit               junk_en;

  always #10 clk = ~clk;

  ptw3_walker dut_i (
    .clk(clk), .rst_n(rst_n), .pt_root_i(pt_root),
    .miss_valid_i(miss_valid), .miss_va_i(miss_va), .miss_ready_o(miss_ready),
    .fill_valid_o(fill_valid), .fill_fault_o(fill_fault), .fill_large_o(fill_large),
    .fill_level_o(fill_level), .fill_pa_o(fill_pa),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  function automatic logic [PTE_W-1:0] rd(input logic [PA_W-1:0] a);
    longint unsigned k = 64'(a);
    return mem.exists(k) ? mem[k] : '0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random acceptance stall, response 1..3 cycles after acceptance
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; pend = 1'b0; lat = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pend_addr);
          pend = 1'b0;
        end else lat--;
      end else if (mem_req_valid && ($urandom % 3 != 0)) begin
        mem_req_ready = 1'b1;
        if (reads < 4) rd_addr[reads] = mem_req_addr;
        reads++;
        pend = 1'b1;
        pend_addr = mem_req_addr;
        lat = $urandom % 3;
      end
    end
  end

  // expected walk from requirements R2..R6, R10
  task automatic model(input logic [VA_W-1:0] va, input logic [PA_W-1:0] root,
                       output bit f, output bit lg, output int lvl, output logic [PA_W-1:0] pa,
                       output int n, output logic [PA_W-1:0] a [3]);
    logic [PTE_W-1:0] e;
    logic [PA_W-1:0] t;
    f = 0; lg = 0; pa = '0;
    a[0] = root + (PA_W'(va[43:33]) * 8); n = 1; lvl = 1;
    e = rd(a[0]);
    a[1] = '0; a[2] = '0;
    if (!e[0] || e[1]) begin f = 1; return; end
    t = {e[PA_W-1:12], 12'h000};
    a[1] = t + (PA_W'(va[32:22]) * 8); n = 2; lvl = 2;
    e = rd(a[1]);
    if (!e[0]) begin f = 1; return; end
    if (e[1]) begin lg = 1; pa = {e[PA_W-1:22], va[21:0]}; return; end
    t = {e[PA_W-1:12], 12'h000};
    a[2] = t + (PA_W'(va[21:12]) * 8); n = 3; lvl = 3;
    e = rd(a[2]);
    if (!e[0]) begin f = 1; return; end
    pa = {e[PA_W-1:12], va[11:0]};
  endtask

  task automatic walk(input logic [VA_W-1:0] va, input string tag);
    bit f, lg; int lvl, n; logic [PA_W-1:0] pa; logic [PA_W-1:0] a [3];
    int cyc;
    string rq;
    model(va, pt_root, f, lg, lvl, pa, n, a);
    reads = 0;
    @(negedge clk);
    chk({"R8 idle ready ", tag}, 64'(miss_ready), 64'd1);
    miss_valid = 1'b1; miss_va = va;
    @(negedge clk);
    miss_valid = 1'b0;
    cyc = 0;
    while (!fill_valid && cyc < 200) begin
      if (junk_en && mem_req_valid) begin miss_valid = 1'b1; miss_va = ~va; end
      else miss_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    miss_valid = 1'b0;
    if (!fill_valid) begin
      chk({"R9 walk timeout ", tag}, 64'd0, 64'd1);
      return;
    end
    rq = f ? "R6" : (lg ? "R5" : "R4");
    if (lvl == 1 && f) rq = "R6/R10";
    chk({rq, " fault ", tag}, 64'(fill_fault), 64'(f));
    chk({rq, " level ", tag}, 64'(fill_level), 64'(lvl));
    chk({rq, " large ", tag}, 64'(fill_large), 64'(lg));
    if (!f) chk({rq, " pa ", tag}, 64'(fill_pa), 64'(pa));
    chk({"R7 read count ", tag}, 64'(reads), 64'(n));
    chk({"R2 L1 addr ", tag}, 64'(rd_addr[0]), 64'(a[0]));
    if (n > 1) chk({"R3 L2 addr ", tag}, 64'(rd_addr[1]), 64'(a[1]));
    if (n > 2) chk({"R3 L3 addr ", tag}, 64'(rd_addr[2]), 64'(a[2]));
    @(negedge clk);
    chk({"R9 pulse ", tag}, 64'(fill_valid), 64'd0);
    chk({"R9 ready again ", tag}, 64'(miss_ready), 64'd1);
  endtask

  function automatic logic [PTE_W-1:0] mk(input logic [PA_W-1:0] frame, input bit v, input bit leaf);
    logic [PTE_W-1:0] e = {$urandom, $urandom};
    e[PA_W-1:12] = frame[PA_W-1:12];
    e[0] = v; e[1] = leaf;
    return e;
  endfunction

  function automatic logic [PA_W-1:0] rbase();
    return {PA_W'({$urandom, $urandom})} & ~PA_W'(12'hfff);
  endfunction

  // builds tables; kind: 0 small,1 large,2 flt L1,3 flt L2,4 flt L3,5 leaf L1,6 small w/ L3 leaf
  task automatic build(input logic [VA_W-1:0] va, input int kind);
    logic [PA_W-1:0] t2, t3, a;
    mem.delete();
    pt_root = rbase();
    t2 = rbase(); t3 = rbase();
    a = pt_root + PA_W'(va[43:33]) * 8;
    mem[64'(a)] = mk(t2, kind != 2, kind == 5);
    a = t2 + PA_W'(va[32:22]) * 8;
    mem[64'(a)] = mk(t3, kind != 3, kind == 1);
    a = t3 + PA_W'(va[21:12]) * 8;
    mem[64'(a)] = mk(rbase(), kind != 4, kind == 6);
  endtask

  initial begin
    #4000000;
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VA_W-1:0] va;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; miss_valid = 1'b0; miss_va = '0; pt_root = '0; junk_en = 1'b0; reads = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(miss_ready), 64'd1);
    chk("R1 reset req", 64'(mem_req_valid), 64'd0);
    chk("R1 reset fill", 64'(fill_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle req", 64'(mem_req_valid), 64'd0);
    chk("R1 idle ready", 64'(miss_ready), 64'd1);

    va = {$urandom, $urandom}; build(va, 0); walk(va, "R4 small");
    va = {$urandom, $urandom}; build(va, 1); walk(va, "R5 large");
    va = {$urandom, $urandom}; build(va, 2); walk(va, "R6 fault L1");
    va = {$urandom, $urandom}; build(va, 3); walk(va, "R6 fault L2");
    va = {$urandom, $urandom}; build(va, 4); walk(va, "R6 fault L3");
    va = {$urandom, $urandom}; build(va, 5); walk(va, "R10 leaf L1");
    va = {$urandom, $urandom}; build(va, 6); walk(va, "R10 leaf L3");
    va = '1; build(va, 0); walk(va, "R2 max index");
    va = '0; build(va, 1); walk(va, "R3 zero index");
    junk_en = 1'b1;
    va = {$urandom, $urandom}; build(va, 0); walk(va, "R8 junk miss");
    for (int i = 0; i < 150; i++) begin
      int r = $urandom % 10;
      int kind = (r < 4) ? 0 : (r < 6) ? 1 : (r < 7) ? 2 : (r < 8) ? 3 : (r < 9) ? 4 : 6;
      junk_en = ($urandom % 2) == 1;
      va = {$urandom, $urandom};
      build(va, kind);
      walk(va, "random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule